// File: doc/BRIEF.md
# Floating-Point Exception Resolver

This block sits behind a single-precision arithmetic core. For each finished operation it takes in the raw result, the sign of the unrounded value, five condition bits, and the rounding mode. The five conditions are invalid, divide-by-zero, overflow, underflow and inexact. It then makes one of two choices. If a condition is present whose enable bit is set, it raises a single trap request and withholds the register writeback. If not, it records the conditions in sticky flags and writes back a substituted default result, or the raw result when no default applies.

The block also holds the status/control word, which software reads and writes. Software clears flags and sets enables through it. After a trap, software reads the condition field to learn which conditions caused it. One result, or one trap, appears on the cycle after each accepted operation.

Top module: `fpu_exc_unit`

## Requirements
- R1: Reset (synchronous, active low) clears the status/control word, `wb_valid` and `trap_req`.
- R2: On an accepted operation with any effective condition whose enable bit is set, `trap_req` is 1 on the next cycle and `wb_valid` is 0. This holds whichever condition or conditions caused it.
- R3: On an accepted operation that does not trap, `wb_valid` is 1 and `trap_req` is 0 on the next cycle. Each effective condition present is ORed into the flags.
- R4: An invalid condition gives the default result 0x7FC00000, a quiet NaN.
- R5: Divide-by-zero gives infinity: bit 31 is `op_sign` and bits 30:0 are 0x7F800000.
- R6: Overflow gives infinity with sign `op_sign` when `op_rnd` is 0 (round to nearest). It gives the largest finite value (bits 30:0 = 0x7F7FFFFF) with that sign when `op_rnd` is 1 (round toward zero).
- R7: Underflow gives zero with sign `op_sign`.
- R8: With only inexact, or with no condition, `op_result` is written back unchanged.
- R9: When several conditions are present, the default result follows the order invalid, then divide-by-zero, then overflow, then underflow.
- R10: Overflow or underflow always counts as inexact as well. The inexact flag is set, and an enabled inexact condition traps.
- R11: Flags are sticky and change only through a write. A write in the same cycle as a committed operation stores the written flags ORed with that operation's conditions.
- R12: Word layout: flags in bits 4:0, enables in bits 9:5, trap condition in bits 14:10. Within each field, bit 4 is invalid, 3 divide-by-zero, 2 overflow, 1 underflow and 0 inexact. Bits 31:15 read 0 and ignore writes. A trapped operation loads its effective conditions into bits 14:10 and leaves the flags unchanged.
- R13: A cycle with no accepted operation raises neither `wb_valid` nor `trap_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation has finished this cycle |
| op_result | input | 32 | Rounded result from the arithmetic core |
| op_sign | input | 1 | Sign of the unrounded value |
| op_cause | input | 5 | Conditions: 4 invalid, 3 div-by-zero, 2 overflow, 1 underflow, 0 inexact |
| op_rnd | input | 1 | Rounding mode: 0 nearest, 1 toward zero |
| csr_wr_en | input | 1 | Write the status/control word |
| csr_wr_data | input | 32 | Data for the write |
| csr_rd_data | output | 32 | Current status/control word |
| wb_valid | output | 1 | Write `wb_data` to the destination register |
| wb_data | output | 32 | Result or default value; 0 when no writeback |
| trap_req | output | 1 | Single floating-point exception request |

## Verification
Each condition is driven alone, with both signs and both rounding modes, to confirm which default pattern it selects. Condition pairs and triples are used to separate the priority order from a simple OR of patterns. Runs with the enables cleared, with one enable set, and with only the inexact enable set show the difference between trapping on a raw condition and trapping on the implied inexact condition. Writes that fall alone or in the same cycle as an operation show whether flags are sticky, whether the writes merge with an update, and whether the unused upper bits are ignored.

// File: rtl/fpu_exc_pkg.sv
// Shared encodings for the floating-point exception resolver.
// Assumes single-precision IEEE-754 results, with bit 31 as the sign.
package fpu_exc_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned NCAUSE  = 5;

    // Condition bit positions; the priority order depends on them.
    localparam int unsigned CZ_I = 0;
    localparam int unsigned CZ_U = 1;
    localparam int unsigned CZ_O = 2;
    localparam int unsigned CZ_Z = 3;
    localparam int unsigned CZ_V = 4;

    // Field positions in the status/control word.
    localparam int unsigned FLAG_LSB  = 0;
    localparam int unsigned EN_LSB    = FLAG_LSB + NCAUSE;
    localparam int unsigned CAUSE_LSB = EN_LSB + NCAUSE;
    localparam int unsigned CSR_USED  = CAUSE_LSB + NCAUSE;

    localparam logic [DATA_W-1:0] QNAN_WORD = 32'h7FC0_0000;
    localparam logic [DATA_W-2:0] INF_MAG   = 31'h7F80_0000;
    localparam logic [DATA_W-2:0] MAXF_MAG  = 31'h7F7F_FFFF;

    typedef logic [NCAUSE-1:0] cause_t;

    typedef enum logic {
        RND_NEAREST = 1'b0,
        RND_ZERO    = 1'b1
    } rnd_t;
endpackage

// File: rtl/fpu_exc_default.sv
// Default-result selector.
// Picks the value to write back from the effective conditions, following
// the priority invalid > div-by-zero > overflow > underflow. Inexact alone
// or no condition passes the raw result through. Purely combinational.
module fpu_exc_default
    import fpu_exc_pkg::*;
(
    input  logic [DATA_W-1:0] raw_i,
    input  logic              sign_i,
    input  cause_t            cause_i,
    input  rnd_t              rnd_i,
    output logic [DATA_W-1:0] result_o
);
    // Priority chain that chooses the substituted value.
    always_comb begin
        if (cause_i[CZ_V]) begin
            result_o = QNAN_WORD;
        end else if (cause_i[CZ_Z]) begin
            result_o = {sign_i, INF_MAG};
        end else if (cause_i[CZ_O]) begin
            result_o = (rnd_i == RND_ZERO) ? {sign_i, MAXF_MAG} : {sign_i, INF_MAG};
        end else if (cause_i[CZ_U]) begin
            result_o = {sign_i, {(DATA_W-1){1'b0}}};
        end else begin
            result_o = raw_i;
        end
    end
endmodule

// File: rtl/fpu_exc_csr.sv
// Status/control word: sticky flags, trap enables and the trap-condition field.
// A software write and a committed update may fall in the same cycle; the
// update is ORed over the written flags. A trapped operation overrides a
// write to the condition field.
module fpu_exc_csr
    import fpu_exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              commit_i,
    input  logic              trap_i,
    input  cause_t            cause_i,
    output cause_t            enables_o,
    output logic [DATA_W-1:0] rd_data_o
);
    cause_t flags_q, en_q, tcause_q;
    cause_t flags_d, en_d, tcause_d;

    // Next-state selection for the three fields.
    always_comb begin
        flags_d  = wr_en_i ? wr_data_i[FLAG_LSB +: NCAUSE] : flags_q;
        if (commit_i) flags_d = flags_d | cause_i;
        en_d     = wr_en_i ? wr_data_i[EN_LSB +: NCAUSE] : en_q;
        tcause_d = wr_en_i ? wr_data_i[CAUSE_LSB +: NCAUSE] : tcause_q;
        if (trap_i) tcause_d = cause_i;
    end

    // Register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q  <= '0;
            en_q     <= '0;
            tcause_q <= '0;
        end else begin
            flags_q  <= flags_d;
            en_q     <= en_d;
            tcause_q <= tcause_d;
        end
    end

    // Read view; unused upper bits read as zero.
    always_comb begin
        rd_data_o = '0;
        rd_data_o[FLAG_LSB +: NCAUSE]  = flags_q;
        rd_data_o[EN_LSB +: NCAUSE]    = en_q;
        rd_data_o[CAUSE_LSB +: NCAUSE] = tcause_q;
    end

    assign enables_o = en_q;

    // R11: without a write, no flag that was set may clear.
    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en_i)) |-> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R12: a trapped operation leaves the flags alone when there is no write.
    assert_trap_keeps_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(trap_i) && !$past(wr_en_i)) |-> $stable(flags_q));
endmodule

// File: rtl/fpu_exc_issue.sv
// Trap decision and output stage.
// Traps when any effective condition has its enable set. Otherwise it
// commits the default result. Outputs are registered, so a result or trap
// shows one cycle after op_valid.
module fpu_exc_issue
    import fpu_exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  cause_t            cause_i,
    input  cause_t            enables_i,
    input  logic [DATA_W-1:0] result_i,
    output logic              take_trap_o,
    output logic              commit_o,
    output logic              trap_req_o,
    output logic              wb_valid_o,
    output logic [DATA_W-1:0] wb_data_o
);
    // Merge every enabled condition into one request.
    always_comb begin
        take_trap_o = valid_i && (|(cause_i & enables_i));
        commit_o    = valid_i && !take_trap_o;
    end

    // Output registers; data is zeroed when nothing is written back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_req_o <= 1'b0;
            wb_valid_o <= 1'b0;
            wb_data_o  <= '0;
        end else begin
            trap_req_o <= take_trap_o;
            wb_valid_o <= commit_o;
            wb_data_o  <= commit_o ? result_i : '0;
        end
    end

    // R2: a trap never goes out together with a writeback.
    assert_trap_excl_wb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_req_o && wb_valid_o));

    // R3: every accepted operation yields exactly one outcome.
    assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i)) |-> (trap_req_o || wb_valid_o));

    // R13: no accepted operation means no outcome.
    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(valid_i)) |-> (!trap_req_o && !wb_valid_o));
endmodule

// File: rtl/fpu_exc_unit.sv
// Top level of the floating-point exception resolver.
// Forces inexact on overflow and underflow, selects the default result,
// decides between a trap and a writeback, and keeps the status/control word.
// Assumes op_cause, op_sign and op_rnd are valid when op_valid is 1.
module fpu_exc_unit
    import fpu_exc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [31:0] op_result,
    input  logic        op_sign,
    input  logic [4:0]  op_cause,
    input  logic        op_rnd,
    input  logic        csr_wr_en,
    input  logic [31:0] csr_wr_data,
    output logic [31:0] csr_rd_data,
    output logic        wb_valid,
    output logic [31:0] wb_data,
    output logic        trap_req
);
    cause_t            eff_cause;
    cause_t            enables;
    logic [DATA_W-1:0] dflt_result;
    logic              take_trap;
    logic              commit;
    rnd_t              rnd;

    // Overflow and underflow imply inexact.
    always_comb begin
        eff_cause       = op_cause;
        eff_cause[CZ_I] = op_cause[CZ_I] | op_cause[CZ_O] | op_cause[CZ_U];
    end

    assign rnd = rnd_t'(op_rnd);

    fpu_exc_default u_default (
        .raw_i    (op_result),
        .sign_i   (op_sign),
        .cause_i  (eff_cause),
        .rnd_i    (rnd),
        .result_o (dflt_result)
    );

    fpu_exc_issue u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (op_valid),
        .cause_i     (eff_cause),
        .enables_i   (enables),
        .result_i    (dflt_result),
        .take_trap_o (take_trap),
        .commit_o    (commit),
        .trap_req_o  (trap_req),
        .wb_valid_o  (wb_valid),
        .wb_data_o   (wb_data)
    );

    fpu_exc_csr u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (csr_wr_en),
        .wr_data_i (csr_wr_data),
        .commit_i  (commit),
        .trap_i    (take_trap),
        .cause_i   (eff_cause),
        .enables_o (enables),
        .rd_data_o (csr_rd_data)
    );

    // R10: a committed overflow or underflow leaves the inexact flag set.
    assert_implied_inexact_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid) && wb_valid &&
         ($past(op_cause[CZ_O]) || $past(op_cause[CZ_U])))
        |-> csr_rd_data[FLAG_LSB + CZ_I]);

    // R6: a committed overflow alone in round-toward-zero writes the largest finite magnitude.
    assert_overflow_rz_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && wb_valid && $past(op_cause[CZ_O]) && !$past(op_cause[CZ_V]) &&
         !$past(op_cause[CZ_Z]) && $past(op_rnd))
        |-> (wb_data[30:0] == MAXF_MAG));

    // R12: unused upper bits always read zero.
    assert_upper_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rd_data[31:CSR_USED] == '0);
endmodule

// File: tb/fpu_exc_unit_test.sv
module fpu_exc_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [31:0] op_result = '0;
    logic        op_sign = 1'b0;
    logic [4:0]  op_cause = '0;
    logic        op_rnd = 1'b0;
    logic        csr_wr_en = 1'b0;
    logic [31:0] csr_wr_data = '0;
    logic [31:0] csr_rd_data;
    logic        wb_valid;
    logic [31:0] wb_data;
    logic        trap_req;

    int unsigned total = 0;
    int unsigned bad = 0;
    int unsigned cyc = 0;
    bit          done = 1'b0;

    typedef struct {
        int unsigned cyc;
        logic        trap;
        logic        wbv;
        logic [31:0] data;
        logic [31:0] csr;
        string       tag;
    } exp_t;
    exp_t q[$];

    logic [14:0] m_csr = '0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fpu_exc_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_result(op_result),
        .op_sign(op_sign), .op_cause(op_cause), .op_rnd(op_rnd),
        .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data), .csr_rd_data(csr_rd_data),
        .wb_valid(wb_valid), .wb_data(wb_data), .trap_req(trap_req)
    );

    // Driver: apply one cycle of stimulus and push the expected outcome.
    task automatic drive(input bit v, input logic [31:0] res, input bit s,
                         input logic [4:0] c, input bit rm, input bit w,
                         input logic [31:0] wd, input string tag);
        logic [4:0]  ec;
        logic [4:0]  fl;
        logic [4:0]  en;
        logic [4:0]  tc;
        logic [31:0] dv;
        bit          tr;
        exp_t        e;
        @(negedge clk);
        op_valid = v; op_result = res; op_sign = s; op_cause = c; op_rnd = rm;
        csr_wr_en = w; csr_wr_data = wd;
        ec = c;
        if (c[2] || c[1]) ec[0] = 1'b1;
        tr = v && ((ec & m_csr[9:5]) != 5'd0);
        if (c[4])      dv = 32'h7FC0_0000;
        else if (c[3]) dv = {s, 31'h7F80_0000};
        else if (c[2]) dv = rm ? {s, 31'h7F7F_FFFF} : {s, 31'h7F80_0000};
        else if (c[1]) dv = {s, 31'h0};
        else           dv = res;
        fl = w ? wd[4:0] : m_csr[4:0];
        if (v && !tr) fl = fl | ec;
        en = w ? wd[9:5] : m_csr[9:5];
        tc = w ? wd[14:10] : m_csr[14:10];
        if (tr) tc = ec;
        m_csr = {tc, en, fl};
        e.cyc = cyc; e.trap = tr; e.wbv = v && !tr;
        e.data = (v && !tr) ? dv : 32'h0;
        e.csr = {17'h0, m_csr}; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare each expected item one cycle after it was driven.
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].cyc < cyc) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (trap_req !== e.trap || wb_valid !== e.wbv || wb_data !== e.data ||
                csr_rd_data !== e.csr) begin
                bad++;
                $display("FAIL %s: got trap=%b wbv=%b data=%h csr=%h exp trap=%b wbv=%b data=%h csr=%h",
                         e.tag, trap_req, wb_valid, wb_data, csr_rd_data,
                         e.trap, e.wbv, e.data, e.csr);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hung exp finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (csr_rd_data !== 32'h0 || wb_valid !== 1'b0 || trap_req !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: got csr=%h wbv=%b trap=%b exp 0 0 0",
                     csr_rd_data, wb_valid, trap_req);
        end
        rst_n = 1'b1;
        // R8: no condition and inexact alone pass the raw result.
        drive(1, 32'h3F80_0000, 0, 5'b00000, 0, 0, 0, "R8 raw no cause");
        drive(1, 32'h4049_0FDB, 0, 5'b00001, 0, 0, 0, "R8 R3 inexact only");
        // R13: idle cycle.
        drive(0, 32'h1234_5678, 1, 5'b11111, 0, 0, 0, "R13 idle");
        // R4..R7 single conditions.
        drive(1, 32'h0, 1, 5'b10000, 0, 0, 0, "R4 invalid qnan");
        drive(1, 32'h0, 1, 5'b01000, 0, 0, 0, "R5 divzero neg inf");
        drive(1, 32'h0, 0, 5'b01000, 1, 0, 0, "R5 divzero pos inf");
        drive(1, 32'h0, 0, 5'b00100, 0, 0, 0, "R6 overflow nearest");
        drive(1, 32'h0, 1, 5'b00100, 1, 0, 0, "R6 overflow toward zero");
        drive(1, 32'h0, 1, 5'b00010, 0, 0, 0, "R7 underflow neg zero");
        // R9 priority.
        drive(1, 32'h0, 1, 5'b11100, 1, 0, 0, "R9 invalid beats others");
        drive(1, 32'h0, 1, 5'b01010, 0, 0, 0, "R9 divzero beats underflow");
        drive(1, 32'h0, 0, 5'b00110, 1, 0, 0, "R9 overflow beats underflow");
        // R11: clear flags, then write and update together.
        drive(0, 32'h0, 0, 5'b00000, 0, 1, 32'h0, "R11 clear");
        drive(1, 32'h0, 0, 5'b00100, 0, 0, 0, "R10 overflow sets inexact");
        drive(0, 32'h0, 0, 5'b00000, 0, 0, 0, "R11 flags sticky");
        drive(1, 32'h0, 0, 5'b01000, 0, 1, 32'h0000_0010, "R11 write merges update");
        // R2 / R12: enable divide-by-zero and trap on it.
        drive(0, 32'h0, 0, 5'b00000, 0, 1, 32'h0000_0100, "R11 enable divzero");
        drive(1, 32'h4000_0000, 1, 5'b01000, 0, 0, 0, "R2 R12 divzero traps");
        drive(1, 32'h0, 0, 5'b10000, 0, 0, 0, "R3 invalid not enabled commits");
        drive(1, 32'h0, 0, 5'b11000, 0, 0, 0, "R2 mixed causes single trap");
        // R10: inexact enable traps on underflow.
        drive(0, 32'h0, 0, 5'b00000, 0, 1, 32'h0000_0020, "R11 enable inexact");
        drive(1, 32'h0, 1, 5'b00010, 0, 0, 0, "R10 underflow traps via inexact");
        drive(1, 32'h0, 1, 5'b00001, 0, 0, 0, "R2 inexact traps");
        // R12: upper bits ignored.
        drive(0, 32'h0, 0, 5'b00000, 0, 1, 32'hFFFF_8000, "R12 upper ignored");
        drive(1, 32'h3F00_0000, 0, 5'b00001, 0, 0, 0, "R8 inexact commits again");
        drive(0, 32'h0, 0, 5'b00000, 0, 0, 0, "R13 final idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule